// File: doc/BRIEF.md
# Test Control Register Bank

This block is the host-facing register bank of a memory traffic tester. The host reads and writes registers by 32-bit word index, through either 32-bit or 64-bit accesses. Registers are grouped in 64-bit slots, one slot per even word index. A 32-bit access reaches one half of a slot: the lower half at the even index and the upper half at the odd index. A 64-bit access reaches both halves, and the low address bit is ignored.

The bank holds a read-only feature header and a 128-bit identifier, plus two scratchpads and a status-memory base address. It also holds the source and destination buffer addresses, a line count, a control word, a configuration word, an inactivity threshold and an interrupt word. It sends the decoded configuration fields and the interrupt fields to the traffic engine. It also drives the engine's test reset level and single-cycle start and force-complete strobes.

Bit 0 of the control word is an active-low soft reset for the test. While it is low, the test configuration registers are held at zero and writes to them are lost. Software first sets bit 0, then configures the test, then writes 0x3 to start the run or 0x7 to force completion.

Top module: `tctl_regbank`

## Requirements
- R1: On synchronous reset every writable register reads zero, `rd_valid` and both strobes are low, and `test_reset_n` is low. Words 0/1 read the low and high halves of `HDR_VALUE`, and words 2/3/4/5 read `ID_VALUE` bits [31:0], [63:32], [95:64] and [127:96].
- R2: A read with `rd_en` high returns its data on `rd_data` with `rd_valid` high in the following cycle, and `rd_valid` is low after a cycle without `rd_en`. Any word index that holds no register reads zero.
- R3: A 32-bit access uses bits [31:0] of the data buses, and the upper 32 bits of `rd_data` return zero. The access touches the lower half of the slot at an even word and the upper half at an odd word. A 64-bit access touches the whole slot at `addr>>1`.
- R4: Writes to words 0x0000 through 0x0009 (header, identifier, and the reserved words 6 to 9) are ignored. The reserved words always read zero.
- R5: The scratchpads at words 0x0040 and 0x0042 store any 64-bit value, and the soft reset does not clear them.
- R6: The status base sits at words 0x0044 (low) and 0x0045 (high) and appears on `dsm_base`. Its bits [5:0] always read zero.
- R7: The control word sits at word 0x004E. Only bits [2:0] are stored, bits [31:3] read zero, and bit 0 drives `test_reset_n`.
- R8: While control bit 0 is 0, the following registers are held at zero and writes to them are ignored: source address (0x0048), destination address (0x004A), line count (0x004C), configuration (0x0050) and inactivity threshold (0x0052).
- R9: `start_pulse` is high for exactly one cycle, in the cycle after a write that turns stored control bit 1 from 0 to 1 while the written bit 0 is 1. A single write of 0x3 from 0x0 qualifies. `force_pulse` follows the same rule for bit 2. Rewriting a bit that is already set gives no pulse.
- R10: Only bits [LINE_BITS-1:0] of the line count are writable, and the others read zero.
- R11: The configuration word drives these fields: `cfg_write_thru` from bit 0, `cfg_rollover` from bit 1, `cfg_mode` from bits [4:2], `cfg_line_len` from [6:5], `cfg_delay_en` from 8, `cfg_rd_type` from [10:9], `cfg_vchan` from [13:12], `cfg_test_opt` from [27:20], `cfg_irq_err` from 28 and `cfg_irq_test` from 29. Bits 7, 11, [19:14], 30 and 31 read zero.
- R12: Interrupt word (0x0054): bits [23:16] drive `irq_vector`, bits [15:0] drive `irq_apic`, and bits [31:24] read zero.
- R13: When a read and a write to the same register happen in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_wide | input | 1 | 1 = 64-bit write, 0 = 32-bit write |
| wr_addr | input | 16 | Write word index |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Read request |
| rd_wide | input | 1 | 1 = 64-bit read, 0 = 32-bit read |
| rd_addr | input | 16 | Read word index |
| rd_data | output | 64 | Read data, one cycle after the request |
| rd_valid | output | 1 | Read data valid |
| test_reset_n | output | 1 | Test soft reset level (control bit 0) |
| start_pulse | output | 1 | One-cycle start strobe |
| force_pulse | output | 1 | One-cycle force-complete strobe |
| dsm_base | output | 64 | Status memory base address |
| src_addr | output | 64 | Source buffer address |
| dst_addr | output | 64 | Destination buffer address |
| num_lines | output | 32 | Line count |
| cfg_mode | output | 3 | Test mode |
| cfg_rollover | output | 1 | Roll over at end of count |
| cfg_write_thru | output | 1 | Write request type select |
| cfg_line_len | output | 2 | Multi-line length |
| cfg_delay_en | output | 1 | Random delay enable |
| cfg_rd_type | output | 2 | Read request type |
| cfg_vchan | output | 2 | Channel select |
| cfg_test_opt | output | 8 | Mode-specific test options |
| cfg_irq_err | output | 1 | Interrupt on error |
| cfg_irq_test | output | 1 | Interrupt at test end |
| inact_thresh | output | 32 | Inactivity threshold |
| irq_vector | output | 8 | Interrupt vector number |
| irq_apic | output | 16 | Interrupt destination identifier |

## Verification
The hardest case to reach is the soft-reset interplay. Configuration values must vanish while control bit 0 is low and must stay zero after it rises again. The control-bit transitions must produce strobes only on the right edges, including a single write that releases reset and starts the run at once. The stimulus covers this with a scripted series of control writes: release, start, repeated start, force, a start attempt while held in reset, and a combined release-and-start. Configuration is written before and during the reset hold and read back after the hold.

// File: rtl/tctl_pkg.sv
package tctl_pkg;

    localparam int ADDR_W = 16;
    localparam int NUM_RW = 10;

    // Writable 64-bit slots; value is the index into the storage array
    typedef enum int {
        RW_SCR0  = 0,
        RW_SCR1  = 1,
        RW_DSM   = 2,
        RW_SRC   = 3,
        RW_DST   = 4,
        RW_LINES = 5,
        RW_CTL   = 6,
        RW_CFG   = 7,
        RW_INACT = 8,
        RW_IRQ   = 9
    } rw_reg_e;

    typedef struct packed {
        logic       irq_test;
        logic       irq_err;
        logic [7:0] test_opt;
        logic [1:0] vchan;
        logic [1:0] rd_type;
        logic       delay_en;
        logic [1:0] line_len;
        logic [2:0] mode;
        logic       rollover;
        logic       write_thru;
    } cfg_fields_t;

    // Slot index (word index >> 1) of each writable register
    function automatic logic [ADDR_W-2:0] rw_slot(int i);
        case (i)
            0:       return 15'h20;
            1:       return 15'h21;
            2:       return 15'h22;
            3:       return 15'h24;
            4:       return 15'h25;
            5:       return 15'h26;
            6:       return 15'h27;
            7:       return 15'h28;
            8:       return 15'h29;
            default: return 15'h2A;
        endcase
    endfunction

    // Bits that hold state in each slot
    function automatic logic [63:0] rw_mask(int i, int line_bits);
        case (i)
            2:       return 64'hFFFF_FFFF_FFFF_FFC0;
            5:       return (64'd1 << line_bits) - 64'd1;
            6:       return 64'h0000_0000_0000_0007;
            7:       return 64'h0000_0000_3FF0_377F;
            8:       return 64'h0000_0000_FFFF_FFFF;
            9:       return 64'h0000_0000_00FF_FFFF;
            default: return 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    // Slots cleared and locked while the test is held in soft reset
    function automatic bit rw_soft(int i);
        return (i == 3) || (i == 4) || (i == 5) || (i == 7) || (i == 8);
    endfunction

    function automatic cfg_fields_t decode_cfg(logic [31:0] w);
        cfg_fields_t f;
        f.write_thru = w[0];
        f.rollover   = w[1];
        f.mode       = w[4:2];
        f.line_len   = w[6:5];
        f.delay_en   = w[8];
        f.rd_type    = w[10:9];
        f.vchan      = w[13:12];
        f.test_opt   = w[27:20];
        f.irq_err    = w[28];
        f.irq_test   = w[29];
        return f;
    endfunction

endpackage

// File: rtl/tctl_slot_reg.sv
module tctl_slot_reg #(
    parameter logic [63:0] MASK = 64'hFFFF_FFFF_FFFF_FFFF,
    parameter bit          SOFT = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hold,
    input  logic        we_lo,
    input  logic        we_hi,
    input  logic [63:0] wdata,
    output logic [63:0] q
);
    logic clear;
    assign clear = rst || (SOFT && hold);

    always_ff @(posedge clk) begin
        if (clear) begin
            q <= '0;
        end else begin
            if (we_lo) q[31:0]  <= wdata[31:0]  & MASK[31:0];
            if (we_hi) q[63:32] <= wdata[63:32] & MASK[63:32];
        end
    end
endmodule

// File: rtl/tctl_strobe.sv
module tctl_strobe (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] ctl,
    output logic       start_pulse,
    output logic       force_pulse
);
    logic [2:1] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= ctl[2:1];
    end

    assign start_pulse = ctl[0] && ctl[1] && !prev[1];
    assign force_pulse = ctl[0] && ctl[2] && !prev[2];
endmodule

// File: rtl/tctl_readback.sv
module tctl_readback
    import tctl_pkg::*;
#(
    parameter logic [63:0]  HDR_VALUE = '0,
    parameter logic [127:0] ID_VALUE  = '0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rd_en,
    input  logic                    rd_wide,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic [NUM_RW-1:0][63:0] q_all,
    output logic [63:0]             rd_data,
    output logic                    rd_valid
);
    logic [ADDR_W-2:0] slot;
    logic [63:0]       full;
    logic [63:0]       sel;

    assign slot = rd_addr[ADDR_W-1:1];

    always_comb begin
        case (slot)
            15'h0:   full = HDR_VALUE;
            15'h1:   full = ID_VALUE[63:0];
            15'h2:   full = ID_VALUE[127:64];
            default: full = '0;
        endcase
        for (int i = 0; i < NUM_RW; i++) begin
            if (slot == rw_slot(i)) full = q_all[i];
        end
        if (rd_wide)         sel = full;
        else if (rd_addr[0]) sel = {32'd0, full[63:32]};
        else                 sel = {32'd0, full[31:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= sel;
        end
    end
endmodule

// File: rtl/tctl_regbank.sv
module tctl_regbank
    import tctl_pkg::*;
#(
    parameter logic [63:0]  HDR_VALUE = 64'h1000_0000_0000_2A01,
    parameter logic [127:0] ID_VALUE  = 128'h5E1F_0C37_9A24_4D6B_8812_F0E3_77A1_C05D,
    parameter int           LINE_BITS = 14
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        wr_wide,
    input  logic [15:0] wr_addr,
    input  logic [63:0] wr_data,
    input  logic        rd_en,
    input  logic        rd_wide,
    input  logic [15:0] rd_addr,
    output logic [63:0] rd_data,
    output logic        rd_valid,
    output logic        test_reset_n,
    output logic        start_pulse,
    output logic        force_pulse,
    output logic [63:0] dsm_base,
    output logic [63:0] src_addr,
    output logic [63:0] dst_addr,
    output logic [31:0] num_lines,
    output logic [2:0]  cfg_mode,
    output logic        cfg_rollover,
    output logic        cfg_write_thru,
    output logic [1:0]  cfg_line_len,
    output logic        cfg_delay_en,
    output logic [1:0]  cfg_rd_type,
    output logic [1:0]  cfg_vchan,
    output logic [7:0]  cfg_test_opt,
    output logic        cfg_irq_err,
    output logic        cfg_irq_test,
    output logic [31:0] inact_thresh,
    output logic [7:0]  irq_vector,
    output logic [15:0] irq_apic
);
    localparam int CTL_IDX = int'(RW_CTL);

    logic [NUM_RW-1:0][63:0] q_all;
    logic [63:0]             wdata_al;
    logic                    hold;
    cfg_fields_t             cfg;

    // A 32-bit write lands in whichever half is selected, so replicate it
    assign wdata_al = wr_wide ? wr_data : {wr_data[31:0], wr_data[31:0]};
    assign hold     = ~q_all[CTL_IDX][0];

    generate
        for (genvar g = 0; g < NUM_RW; g++) begin : g_slot
            logic hit;
            logic we_lo;
            logic we_hi;
            assign hit   = wr_en && (wr_addr[ADDR_W-1:1] == rw_slot(g));
            assign we_lo = hit && (wr_wide || !wr_addr[0]);
            assign we_hi = hit && (wr_wide ||  wr_addr[0]);
            tctl_slot_reg #(
                .MASK (rw_mask(g, LINE_BITS)),
                .SOFT (rw_soft(g))
            ) u_slot (
                .clk   (clk),
                .rst   (rst),
                .hold  (hold),
                .we_lo (we_lo),
                .we_hi (we_hi),
                .wdata (wdata_al),
                .q     (q_all[g])
            );
        end
    endgenerate

    tctl_strobe u_strobe (
        .clk         (clk),
        .rst         (rst),
        .ctl         (q_all[CTL_IDX][2:0]),
        .start_pulse (start_pulse),
        .force_pulse (force_pulse)
    );

    tctl_readback #(
        .HDR_VALUE (HDR_VALUE),
        .ID_VALUE  (ID_VALUE)
    ) u_readback (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .rd_wide  (rd_wide),
        .rd_addr  (rd_addr),
        .q_all    (q_all),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assign cfg            = decode_cfg(q_all[int'(RW_CFG)][31:0]);
    assign test_reset_n   = q_all[CTL_IDX][0];
    assign dsm_base       = q_all[int'(RW_DSM)];
    assign src_addr       = q_all[int'(RW_SRC)];
    assign dst_addr       = q_all[int'(RW_DST)];
    assign num_lines      = q_all[int'(RW_LINES)][31:0];
    assign inact_thresh   = q_all[int'(RW_INACT)][31:0];
    assign irq_vector     = q_all[int'(RW_IRQ)][23:16];
    assign irq_apic       = q_all[int'(RW_IRQ)][15:0];
    assign cfg_mode       = cfg.mode;
    assign cfg_rollover   = cfg.rollover;
    assign cfg_write_thru = cfg.write_thru;
    assign cfg_line_len   = cfg.line_len;
    assign cfg_delay_en   = cfg.delay_en;
    assign cfg_rd_type    = cfg.rd_type;
    assign cfg_vchan      = cfg.vchan;
    assign cfg_test_opt   = cfg.test_opt;
    assign cfg_irq_err    = cfg.irq_err;
    assign cfg_irq_test   = cfg.irq_test;
endmodule

// File: rtl/tctl_regbank_chk.sv
module tctl_regbank_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic        rd_en,
    input logic        rd_valid,
    input logic        test_reset_n,
    input logic        start_pulse,
    input logic        force_pulse,
    input logic [63:0] src_addr,
    input logic [63:0] dst_addr,
    input logic [31:0] num_lines,
    input logic [31:0] inact_thresh,
    input logic [2:0]  cfg_mode
);
    a_r2_valid_after_read: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    a_r2_no_valid_when_idle: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

    a_r9_start_one_cycle: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);

    a_r9_force_one_cycle: assert property (@(posedge clk) disable iff (rst)
        force_pulse |=> !force_pulse);

    a_r9_start_only_released: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> test_reset_n);

    a_r9_start_follows_write: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> $past(wr_en));

    a_r8_held_clear: assert property (@(posedge clk) disable iff (rst)
        !test_reset_n |=> (src_addr == 64'd0 && dst_addr == 64'd0 &&
                           num_lines == 32'd0 && inact_thresh == 32'd0 &&
                           cfg_mode == 3'd0));

    a_r8_stable_without_write: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && test_reset_n) |=> ($stable(src_addr) && $stable(num_lines)));
endmodule

bind tctl_regbank tctl_regbank_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .rd_valid     (rd_valid),
    .test_reset_n (test_reset_n),
    .start_pulse  (start_pulse),
    .force_pulse  (force_pulse),
    .src_addr     (src_addr),
    .dst_addr     (dst_addr),
    .num_lines    (num_lines),
    .inact_thresh (inact_thresh),
    .cfg_mode     (cfg_mode)
);

// File: tb/tctl_regbank_test.sv
module tctl_regbank_test;
    localparam logic [63:0]  HDR = 64'h1000_0000_0000_2A01;
    localparam logic [127:0] IDV = 128'h5E1F_0C37_9A24_4D6B_8812_F0E3_77A1_C05D;
    localparam int           LB  = 14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_wide = 1'b0, rd_en = 1'b0, rd_wide = 1'b0;
    logic [15:0] wr_addr = '0, rd_addr = '0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data, dsm_base, src_addr, dst_addr;
    logic        rd_valid, test_reset_n, start_pulse, force_pulse;
    logic [31:0] num_lines, inact_thresh;
    logic [2:0]  cfg_mode;
    logic        cfg_rollover, cfg_write_thru, cfg_delay_en, cfg_irq_err, cfg_irq_test;
    logic [1:0]  cfg_line_len, cfg_rd_type, cfg_vchan;
    logic [7:0]  cfg_test_opt, irq_vector;
    logic [15:0] irq_apic;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    tctl_regbank #(.HDR_VALUE(HDR), .ID_VALUE(IDV), .LINE_BITS(LB)) uut (
        .clk, .rst, .wr_en, .wr_wide, .wr_addr, .wr_data, .rd_en, .rd_wide,
        .rd_addr, .rd_data, .rd_valid, .test_reset_n, .start_pulse, .force_pulse,
        .dsm_base, .src_addr, .dst_addr, .num_lines, .cfg_mode, .cfg_rollover,
        .cfg_write_thru, .cfg_line_len, .cfg_delay_en, .cfg_rd_type, .cfg_vchan,
        .cfg_test_opt, .cfg_irq_err, .cfg_irq_test, .inact_thresh, .irq_vector,
        .irq_apic
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [63:0] d, logic wide);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_wide = wide;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, logic wide, output logic [63:0] d);
        rd_en = 1'b1; rd_addr = a; rd_wide = wide;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    // Writable bits of each 32-bit word, from the requirements
    function automatic logic [31:0] wmask(int w);
        case (w)
            'h40, 'h41, 'h42, 'h43, 'h45, 'h48, 'h49, 'h4A, 'h4B, 'h52:
                return 32'hFFFF_FFFF;
            'h44: return 32'hFFFF_FFC0;
            'h4C: return (32'd1 << LB) - 32'd1;
            'h4E: return 32'h7;
            'h50: return 32'h3FF0_377F;
            'h54: return 32'h00FF_FFFF;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] roval(int w);
        case (w)
            0: return HDR[31:0];
            1: return HDR[63:32];
            2: return IDV[31:0];
            3: return IDV[63:32];
            4: return IDV[95:64];
            5: return IDV[127:96];
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(int w);
        if (w < 6)                return "R1";
        if (w < 10)               return "R4";
        if (w >= 'h40 && w < 'h44) return "R5";
        if (w == 'h44 || w == 'h45) return "R6";
        if (w == 'h4C)            return "R10";
        if (w == 'h50)            return "R11";
        if (w == 'h54)            return "R12";
        if (wmask(w) != 0)        return "R3";
        return "R2";
    endfunction

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] d;
        logic [31:0] p;
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 rd_valid", {63'd0, rd_valid}, 64'd0);
        chk("R1 test_reset_n", {63'd0, test_reset_n}, 64'd0);
        chk("R1 strobes", {62'd0, start_pulse, force_pulse}, 64'd0);
        chk("R1 src_addr", src_addr, 64'd0);
        rd(16'h0, 1'b1, d); chk("R1 header wide", d, HDR);
        rd(16'h2, 1'b1, d); chk("R1 id low wide", d, IDV[63:0]);
        rd(16'h5, 1'b1, d); chk("R1 id high wide", d, IDV[127:64]);
        @(negedge clk);
        chk("R2 rd_valid idle", {63'd0, rd_valid}, 64'd0);
        for (int w = 0; w < 'h60; w++) begin
            rd(16'(w), 1'b0, d);
            chk({tag_of(w), " reset read"}, d, {32'd0, roval(w)});
        end

        // R7 release soft reset
        wr(16'h4E, 64'hFFFF_FFF9, 1'b0);
        chk("R7 test_reset_n", {63'd0, test_reset_n}, 64'd1);
        rd(16'h4E, 1'b0, d); chk("R7 ctl readback", d, 64'h1);
        @(negedge clk);

        // Sweep: 32-bit write/readback of every word except control
        for (int w = 0; w < 'h60; w++) begin
            if (w == 'h4E) continue;
            p = 32'hDEAD_BEEF ^ (32'(w) * 32'h0101_0101);
            wr(16'(w), {32'hFFFF_FFFF, p}, 1'b0);
            rd(16'(w), 1'b0, d);
            chk({tag_of(w), " sweep"}, d, {32'd0, (w < 6) ? roval(w) : (p & wmask(w))});
        end

        // R3 wide and half accesses
        wr(16'h48, 64'h0123_4567_89AB_CDEF, 1'b1);
        rd(16'h48, 1'b1, d); chk("R3 wide read", d, 64'h0123_4567_89AB_CDEF);
        rd(16'h49, 1'b0, d); chk("R3 odd half read", d, 64'h0123_4567);
        chk("R3 src port", src_addr, 64'h0123_4567_89AB_CDEF);
        wr(16'h49, 64'h1111_2222_CAFE_F00D, 1'b0);
        chk("R3 upper half write", src_addr, 64'hCAFE_F00D_89AB_CDEF);
        wr(16'h4A, 64'h0, 1'b0);
        wr(16'h4B, 64'hFFFF_FFFF_A5A5_5A5A, 1'b1);
        chk("R3 wide write odd addr", dst_addr, 64'hFFFF_FFFF_A5A5_5A5A);
        wr(16'h0, 64'h0, 1'b1);
        rd(16'h0, 1'b1, d); chk("R4 header unchanged", d, HDR);
        wr(16'h44, 64'h8765_4321_FFFF_FFFF, 1'b1);
        chk("R6 dsm port", dsm_base, 64'h8765_4321_FFFF_FFC0);

        // R11 decode
        v = 32'h2150_254E;
        wr(16'h50, {32'd0, v}, 1'b0);
        chk("R11 mode", {61'd0, cfg_mode}, {61'd0, v[4:2]});
        chk("R11 flags", {58'd0, cfg_write_thru, cfg_rollover, cfg_delay_en,
                          cfg_irq_err, cfg_irq_test, 1'b0},
            {58'd0, v[0], v[1], v[8], v[28], v[29], 1'b0});
        chk("R11 multi", {50'd0, cfg_line_len, cfg_rd_type, cfg_vchan, cfg_test_opt},
            {50'd0, v[6:5], v[10:9], v[13:12], v[27:20]});
        wr(16'h4C, 64'hFFFF_FFFF, 1'b0);
        chk("R10 line port", {32'd0, num_lines}, 64'h3FFF);

        // R12 interrupt word
        wr(16'h54, 64'hFFAB_1234, 1'b0);
        chk("R12 fields", {40'd0, irq_vector, irq_apic}, 64'hAB_1234);

        // R9 strobes
        wr(16'h4E, 64'h3, 1'b0);
        chk("R9 start pulse", {62'd0, start_pulse, force_pulse}, 64'b10);
        @(negedge clk);
        chk("R9 start ends", {62'd0, start_pulse, force_pulse}, 64'b00);
        wr(16'h4E, 64'h3, 1'b0);
        chk("R9 no repeat", {62'd0, start_pulse, force_pulse}, 64'b00);
        wr(16'h4E, 64'h7, 1'b0);
        chk("R9 force pulse", {62'd0, start_pulse, force_pulse}, 64'b01);
        @(negedge clk);
        chk("R9 force ends", {63'd0, force_pulse}, 64'd0);
        wr(16'h4E, 64'h0, 1'b0);
        wr(16'h4E, 64'h2, 1'b0);
        chk("R9 no start in reset", {63'd0, start_pulse}, 64'd0);
        wr(16'h4E, 64'h0, 1'b0);
        wr(16'h4E, 64'h3, 1'b0);
        chk("R9 release and start", {63'd0, start_pulse}, 64'd1);
        wr(16'h4E, 64'h1, 1'b0);

        // R8 soft reset
        wr(16'h48, 64'h1234_5678_9ABC_DEF0, 1'b1);
        wr(16'h40, 64'hFEED_FACE_0BAD_F00D, 1'b1);
        wr(16'h4E, 64'h0, 1'b0);
        @(negedge clk);
        chk("R8 src cleared", src_addr, 64'd0);
        chk("R8 others cleared", {num_lines, inact_thresh}, 64'd0);
        rd(16'h50, 1'b0, d); chk("R8 cfg cleared", d, 64'd0);
        wr(16'h48, 64'h5555_5555_5555_5555, 1'b1);
        rd(16'h48, 1'b1, d); chk("R8 write ignored", d, 64'd0);
        rd(16'h40, 1'b1, d); chk("R5 scratch kept", d, 64'hFEED_FACE_0BAD_F00D);
        wr(16'h4E, 64'h1, 1'b0);
        rd(16'h48, 1'b1, d); chk("R8 stays clear", d, 64'd0);

        // R13 same-cycle read and write
        wr_en = 1'b1; wr_addr = 16'h42; wr_data = 64'hAAAA_BBBB_CCCC_DDDD; wr_wide = 1'b1;
        wr(16'h42, 64'h1, 1'b1);
        wr_en = 1'b1; wr_addr = 16'h42; wr_data = 64'h2; wr_wide = 1'b1;
        rd_en = 1'b1; rd_addr = 16'h42; rd_wide = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R13 old value", d == d ? rd_data : 64'd0, 64'h1);
        rd(16'h42, 1'b1, d); chk("R13 new value", d, 64'h2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule